// File: doc/BRIEF.md
# DMA Event Flag Bank

This block gathers the completion, half-way and error events raised by a set of DMA channels and holds them as sticky flags. All flags are visible at once as one status word, four bits per channel. Software removes flags by writing ones into a separate clear word, because reading the status never changes it. Each channel's group also carries a summary bit that is set whenever any of that channel's three event flags is set. Writing the summary bit's clear position wipes the whole group.

Each channel also drives one interrupt line. The line is raised when a set flag meets its matching per-event enable. A per-channel reset input, used when a channel is torn down, empties that channel's group. The channel datapath that produces the event pulses is outside this block.

Top module: `dma_evt_flag_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every status bit and every interrupt line is low after that edge.
- R2: Channel c (counting from 0) owns status bits 4c to 4c+3. Bit 4c is the summary flag, 4c+1 is transfer complete, 4c+2 is half transfer and 4c+3 is transfer error. The clear word uses the same positions.
- R3: A one-cycle event pulse sets its flag, which is visible after the next clock edge. The flag then stays set in later cycles until a clear or a channel reset removes it.
- R4: The summary flag of a channel is high exactly when at least one of that channel's complete, half or error flags is high.
- R5: With `clr_wr` high, a one at a complete, half or error position clears only that flag. A zero at any position, and every bit of other channels' groups, leaves the flags unchanged.
- R6: With `clr_wr` high, a one at a channel's summary position clears all three of that channel's event flags, and the summary flag with them.
- R7: If an event pulse and a clear for the same flag arrive in the same cycle, the flag is set after the edge.
- R8: A high `chan_rst` bit clears all four flags of that channel after the edge, even if events for it arrive in the same cycle. Other channels are unaffected.
- R9: A channel's interrupt line is high when (complete AND complete-enable) OR (half AND half-enable) OR (error AND error-enable) holds. Both the flags and the enables are those present at the edge that updates the status word.
- R10: When `clr_wr` is low, `clr_data` has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | NCH | Per-channel transfer-complete event pulse |
| evt_half | input | NCH | Per-channel half-transfer event pulse |
| evt_err | input | NCH | Per-channel transfer-error event pulse |
| chan_rst | input | NCH | Per-channel group reset (channel teardown) |
| clr_wr | input | 1 | Write strobe for the clear word |
| clr_data | input | 4*NCH | Clear word, one bit per flag position |
| irq_en_done | input | NCH | Per-channel complete interrupt enable |
| irq_en_half | input | NCH | Per-channel half interrupt enable |
| irq_en_err | input | NCH | Per-channel error interrupt enable |
| flag_status | output | 4*NCH | Registered status word |
| chan_irq | output | NCH | Registered per-channel interrupt line |

## Verification
Every channel receives all eight combinations of the three events, which exposes wrong bit positions and a summary flag that ignores one source. Each channel also sees all sixteen clear patterns over a fully set group, which separates single-flag clears from the summary-clear expansion and from leakage into neighbour groups. Simultaneous event and clear, and simultaneous event and channel reset, fix the priorities. A full sweep of flag contents against enable masks on each channel checks the interrupt gating term by term, and mixed traffic on all channels at once catches cross-channel coupling.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
  localparam int GRP_W    = 4;
  localparam int POS_SUM  = 0;
  localparam int POS_DONE = 1;
  localparam int POS_HALF = 2;
  localparam int POS_ERR  = 3;

  typedef struct packed {
    logic err;
    logic half;
    logic done;
  } evt_vec_t;
endpackage

// File: rtl/dma_clr_decode.sv
module dma_clr_decode #(
  parameter int NCH = 7
) (
  input  logic                             wr,
  input  logic [dma_flag_pkg::GRP_W*NCH-1:0] data,
  output logic [NCH-1:0]                   clr_done,
  output logic [NCH-1:0]                   clr_half,
  output logic [NCH-1:0]                   clr_err
);
  import dma_flag_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BASE = GRP_W * c;
    logic sum_hit;
    // the summary position fans out to all three event flags
    assign sum_hit     = data[BASE + POS_SUM];
    assign clr_done[c] = wr & (sum_hit | data[BASE + POS_DONE]);
    assign clr_half[c] = wr & (sum_hit | data[BASE + POS_HALF]);
    assign clr_err[c]  = wr & (sum_hit | data[BASE + POS_ERR]);
  end
endmodule

// File: rtl/dma_flag_chan.sv
module dma_flag_chan (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      chan_rst,
  input  dma_flag_pkg::evt_vec_t    evt,
  input  dma_flag_pkg::evt_vec_t    clr,
  input  dma_flag_pkg::evt_vec_t    en,
  output logic [dma_flag_pkg::GRP_W-1:0] grp,
  output logic                      irq
);
  import dma_flag_pkg::*;

  evt_vec_t flags_q, flags_d;
  logic     sum_q;
  logic     irq_q;

  // event beats clear; channel reset beats both
  always_comb begin
    if (chan_rst) flags_d = '0;
    else          flags_d = (flags_q & ~clr) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      sum_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      sum_q   <= |flags_d;
      irq_q   <= |(flags_d & en);
    end
  end

  always_comb begin
    grp           = '0;
    grp[POS_SUM]  = sum_q;
    grp[POS_DONE] = flags_q.done;
    grp[POS_HALF] = flags_q.half;
    grp[POS_ERR]  = flags_q.err;
  end
  assign irq = irq_q;

  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    (!chan_rst && evt.done) |=> grp[POS_DONE]);
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (!chan_rst && clr.half && !evt.half) |=> !grp[POS_HALF]);
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (grp[POS_ERR] && !clr.err && !chan_rst) |=> grp[POS_ERR]);
  a_r8_chan_reset: assert property (@(posedge clk) disable iff (rst)
    chan_rst |=> (grp == '0));
  a_r4_summary: assert property (@(posedge clk) disable iff (rst)
    grp[POS_SUM] == (grp[POS_DONE] | grp[POS_HALF] | grp[POS_ERR]));
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
    !$rose(rst) |-> (irq == |({grp[POS_ERR], grp[POS_HALF], grp[POS_DONE]} & $past(en))));
endmodule

// File: rtl/dma_evt_flag_bank.sv
module dma_evt_flag_bank #(
  parameter int NCH = 7
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NCH-1:0]                   evt_done,
  input  logic [NCH-1:0]                   evt_half,
  input  logic [NCH-1:0]                   evt_err,
  input  logic [NCH-1:0]                   chan_rst,
  input  logic                             clr_wr,
  input  logic [dma_flag_pkg::GRP_W*NCH-1:0] clr_data,
  input  logic [NCH-1:0]                   irq_en_done,
  input  logic [NCH-1:0]                   irq_en_half,
  input  logic [NCH-1:0]                   irq_en_err,
  output logic [dma_flag_pkg::GRP_W*NCH-1:0] flag_status,
  output logic [NCH-1:0]                   chan_irq
);
  import dma_flag_pkg::*;

  localparam int STAT_W = GRP_W * NCH;

  logic [NCH-1:0] clr_done, clr_half, clr_err;

  dma_clr_decode #(.NCH(NCH)) clr_dec_i (
    .wr       (clr_wr),
    .data     (clr_data),
    .clr_done (clr_done),
    .clr_half (clr_half),
    .clr_err  (clr_err)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BASE = GRP_W * c;
    evt_vec_t ev, cl, en;
    assign ev = '{err: evt_err[c], half: evt_half[c], done: evt_done[c]};
    assign cl = '{err: clr_err[c], half: clr_half[c], done: clr_done[c]};
    assign en = '{err: irq_en_err[c], half: irq_en_half[c], done: irq_en_done[c]};

    dma_flag_chan chan_i (
      .clk      (clk),
      .rst      (rst),
      .chan_rst (chan_rst[c]),
      .evt      (ev),
      .clr      (cl),
      .en       (en),
      .grp      (flag_status[BASE +: GRP_W]),
      .irq      (chan_irq[c])
    );

    a_r6_summary_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && clr_data[BASE + POS_SUM] && !evt_done[c] && !evt_half[c] && !evt_err[c])
        |=> (flag_status[BASE +: GRP_W] == '0));
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (rst)
      (!clr_wr && !chan_rst[c]) |=>
        ((flag_status[BASE + POS_DONE] | !$past(flag_status[BASE + POS_DONE])) &&
         (flag_status[BASE + POS_ERR]  | !$past(flag_status[BASE + POS_ERR]))));
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (flag_status == '0 && chan_irq == '0));

  logic [STAT_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: tb/dma_evt_flag_bank_tb_top.sv
module dma_evt_flag_bank_tb_top;
  localparam int NCH = 7;
  localparam int SW  = 4 * NCH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] ev_d = '0, ev_h = '0, ev_e = '0, crst = '0;
  logic clr_wr = 1'b0;
  logic [SW-1:0] clr_data = '0;
  logic [NCH-1:0] en_d = '0, en_h = '0, en_e = '0;
  logic [SW-1:0] status;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [2:0] mdl [NCH];   // {err,half,done}
  logic [NCH-1:0] mirq;

  always #2 clk = ~clk;

  dma_evt_flag_bank #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .evt_done(ev_d), .evt_half(ev_h), .evt_err(ev_e),
    .chan_rst(crst), .clr_wr(clr_wr), .clr_data(clr_data),
    .irq_en_done(en_d), .irq_en_half(en_h), .irq_en_err(en_e),
    .flag_status(status), .chan_irq(irq)
  );

  function automatic logic [SW-1:0] exp_status();
    logic [SW-1:0] s = '0;
    for (int c = 0; c < NCH; c++) begin
      s[4*c]   = |mdl[c];
      s[4*c+1] = mdl[c][0];
      s[4*c+2] = mdl[c][1];
      s[4*c+3] = mdl[c][2];
    end
    return s;
  endfunction

  task automatic check(input string tag);
    logic [SW-1:0] es = exp_status();
    checks++;
    if (status !== es) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, es);
    end
    checks++;
    if (irq !== mirq) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, mirq);
    end
  endtask

  // model update from the requirements, then one edge, then check
  task automatic tick(input string tag);
    for (int c = 0; c < NCH; c++) begin
      logic [2:0] cl, ev;
      ev = {ev_e[c], ev_h[c], ev_d[c]};
      cl = clr_wr ? (clr_data[4*c+3 -: 3] | {3{clr_data[4*c]}}) : 3'b000;
      if (crst[c]) mdl[c] = 3'b000;
      else         mdl[c] = (mdl[c] & ~cl) | ev;
      mirq[c] = |(mdl[c] & {en_e[c], en_h[c], en_d[c]});
    end
    @(posedge clk); #1;
    ev_d = '0; ev_h = '0; ev_e = '0; crst = '0; clr_wr = 1'b0; clr_data = '0;
    check(tag);
  endtask

  task automatic wipe();
    clr_wr = 1'b1; clr_data = '1;
    tick("R6 wipe");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) mdl[c] = 3'b000;
    mirq = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after release");

    // R2 R3 R4: all event combinations per channel, then summary clear
    for (int c = 0; c < NCH; c++) begin
      for (int p = 1; p < 8; p++) begin
        ev_d[c] = p[0]; ev_h[c] = p[1]; ev_e[c] = p[2];
        tick("R2 R4 set");
        tick("R3 sticky");
        clr_wr = 1'b1; clr_data[4*c] = 1'b1;
        tick("R6 summary clear");
      end
    end

    // R5 R6: every clear pattern over a full group, neighbours full too
    for (int c = 0; c < NCH; c++) begin
      for (int q = 0; q < 16; q++) begin
        ev_d = '1; ev_h = '1; ev_e = '1;
        tick("R3 fill");
        clr_wr = 1'b1; clr_data[4*c +: 4] = q[3:0];
        tick("R5 pattern clear");
      end
    end

    // R10: data without strobe
    ev_d = '1; ev_h = '1; ev_e = '1;
    tick("R3 fill");
    clr_data = '1;
    tick("R10 no strobe");

    // R7: event and clear together
    for (int c = 0; c < NCH; c++) begin
      clr_wr = 1'b1; clr_data[4*c] = 1'b1;
      ev_h[c] = 1'b1;
      tick("R7 event wins");
      clr_wr = 1'b1; clr_data[4*c+3] = 1'b1; ev_e[c] = 1'b1;
      tick("R7 event wins single");
    end

    // R8: channel reset beats events, leaves others
    for (int c = 0; c < NCH; c++) begin
      ev_d = '1; ev_h = '1; ev_e = '1;
      tick("R3 fill");
      crst[c] = 1'b1; ev_d[c] = 1'b1; ev_e[c] = 1'b1;
      tick("R8 channel reset");
    end
    wipe();

    // R9: flag contents x enable masks per channel
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < 8; e++) begin
        en_d = '0; en_h = '0; en_e = '0;
        en_d[c] = e[0]; en_h[c] = e[1]; en_e[c] = e[2];
        for (int f = 1; f < 8; f++) begin
          ev_d[c] = f[0]; ev_h[c] = f[1]; ev_e[c] = f[2];
          tick("R9 irq gate");
          clr_wr = 1'b1; clr_data[4*c] = 1'b1;
          tick("R9 irq drop");
        end
      end
    end

    // mixed traffic on all channels
    en_d = 7'b1010101; en_h = 7'b0110011; en_e = 7'b1111000;
    for (int k = 0; k < 40; k++) begin
      for (int c = 0; c < NCH; c++) begin
        int v = (k * 5 + c * 3) % 8;
        ev_d[c] = v[0]; ev_h[c] = v[1]; ev_e[c] = v[2];
      end
      clr_wr = k[0];
      for (int b = 0; b < SW; b++) clr_data[b] = ((k * 7 + b * 11) % 5) == 0;
      crst = (k % 9 == 0) ? NCH'(1 << (k % NCH)) : '0;
      tick("R5 R7 R8 R9 mixed");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule